// File: doc/BRIEF.md
# Repartitionable Direct-Mapped Cache

This block is a direct-mapped cache built around one shared tag and line store. The default size is 512 lines of four 32-bit words. A control write picks how that store is divided. In split mode, instruction fetches use the lower half and data accesses use the upper half. Instruction-only mode and data-only mode give the whole store to one side. Off mode sends every access straight to memory. The data side is write-through: every store is written to memory. A store that hits also updates the cached word. A store that misses does not allocate a line.

Requesters present an instruction port and a data port. Each holds its request until it sees a one-cycle acknowledge. All addresses are word addresses. A read miss fills the whole line from the memory-side port, one word per memory transfer, before it answers. A control write may request invalidate-all for either side or both. The block then clears the lines that the new configuration gives to those sides, one line per cycle, and raises `busy` for the length of that walk. While `busy` is high, accesses and further control writes wait or are dropped.

Top module: `cfg_cache`

## Requirements
- R1: After reset, `busy`, `if_ack`, `dc_ack` and `mem_req` are low, and the cache is in off mode.
- R2: The mode comes from the control fields: `ctl_en`=0 gives off, {`ctl_dis_i`,`ctl_dis_d`}=00 gives split, 01 gives instruction-only, 10 gives data-only and 11 gives off. In off mode, every read is one single-word memory read that returns the memory word, and nothing is retained.
- R3: In split mode, instruction lines index the lower half of the store as {0, addr[WSEL+HALF-1:WSEL]} and data lines index the upper half as {1, same bits}. The two sides never evict each other, even for the same address.
- R4: In instruction-only mode, instruction fetches index all lines using addr[WSEL+IDX_W-1:WSEL]. Data accesses bypass the cache and take one memory transfer each.
- R5: In data-only mode, data accesses index all lines in the same way. Instruction fetches bypass the cache.
- R6: A read miss on a cacheable side makes LINE_WORDS memory reads at ascending word addresses, starting at the line base, and then returns the requested word. Later reads of any word of that line hit and make no memory transfer.
- R7: Every data store makes exactly one memory write. A store hit also updates the cached word, so a following read returns the new value with no memory transfer. A store miss leaves the store unchanged, so a following read misses.
- R8: In split mode, invalidating only one side clears only that side's half, and the walk takes LINES/2 cycles of `busy`. A control write with neither invalidate bit set starts no walk.
- R9: Invalidating both sides in split mode, or the active side in a unified mode, clears every line and takes LINES cycles of `busy`. An invalidate request for a side that has no lines in the new mode, or any invalidate in off mode, does nothing.
- R10: `mem_req` is only high while `busy` is high. No access is served while a walk is running.
- R11: When both ports request in the same idle cycle, the data port is served first.
- R12: Two addresses on the same side that share an index but differ in tag replace each other.
- R13: Each acknowledge is a one-cycle pulse that follows a pending request of its port. The two acknowledges are never high together. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe, taken only while `busy` is low |
| ctl_en | input | 1 | Global cache enable |
| ctl_dis_i | input | 1 | Instruction side disable |
| ctl_dis_d | input | 1 | Data side disable |
| ctl_inv_i | input | 1 | Invalidate-all request for the instruction side |
| ctl_inv_d | input | 1 | Invalidate-all request for the data side |
| busy | output | 1 | An access or an invalidate walk is in progress |
| if_req | input | 1 | Instruction fetch request, held until `if_ack` |
| if_addr | input | ADDR_W | Instruction word address |
| if_ack | output | 1 | Fetch complete pulse |
| if_rdata | output | DATA_W | Fetched word, valid with `if_ack` |
| dc_req | input | 1 | Data access request, held until `dc_ack` |
| dc_we | input | 1 | Data access is a store |
| dc_addr | input | ADDR_W | Data word address |
| dc_wdata | input | DATA_W | Store data |
| dc_ack | output | 1 | Data access complete pulse |
| dc_rdata | output | DATA_W | Load data, valid with `dc_ack` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transfer complete pulse |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the block with 8-bit word addresses, IDX_W=3 and four-word lines. That gives eight lines, four per half in split mode, and a 256-word memory that the bench models in full. At this size the bench can fill every line of each half and of the whole store. It can then reread every word to confirm hits, force evictions by changing the tag bits, and check walk lengths of 4 and 8 cycles exactly. Expected data come from the bench's memory array, and expected transfer counts come from the line size and the mode rules.

// File: rtl/cfg_cache_pkg.sv
package cfg_cache_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SPLIT = 2'd1,
        MODE_IONLY = 2'd2,
        MODE_DONLY = 2'd3
    } cache_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_WRITE  = 3'd2,
        ST_BYPASS = 3'd3,
        ST_INVAL  = 3'd4
    } cache_state_e;

endpackage

// File: rtl/cfg_cache_mode_dec.sv
module cfg_cache_mode_dec
    import cfg_cache_pkg::*;
(
    input  logic        en,
    input  logic        dis_i,
    input  logic        dis_d,
    output cache_mode_e mode
);
    always_comb begin
        if (!en) begin
            mode = MODE_OFF;
        end else begin
            case ({dis_i, dis_d})
                2'b00:   mode = MODE_SPLIT;
                2'b01:   mode = MODE_IONLY;
                2'b10:   mode = MODE_DONLY;
                default: mode = MODE_OFF;
            endcase
        end
    end
endmodule

// File: rtl/cfg_cache_index_map.sv
module cfg_cache_index_map
    import cfg_cache_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int IDX_W  = 9,
    parameter int WSEL_W = 2
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               side_d,
    input  cache_mode_e                        mode,
    output logic [IDX_W-1:0]                   idx,
    output logic [ADDR_W-WSEL_W-IDX_W:0]       tag,
    output logic [WSEL_W-1:0]                  wsel,
    output logic                               cacheable
);
    localparam int HALF_W = IDX_W - 1;

    always_comb begin
        wsel = addr[WSEL_W-1:0];
        // tag always sized for the half-store partition; the extra bit is
        // redundant with the top index bit in a unified mode
        tag  = addr[ADDR_W-1:WSEL_W+HALF_W];
        if (mode == MODE_SPLIT) begin
            idx = {side_d, addr[WSEL_W+HALF_W-1:WSEL_W]};
        end else begin
            idx = addr[WSEL_W+IDX_W-1:WSEL_W];
        end
        cacheable = (mode == MODE_SPLIT)
                 || (mode == MODE_IONLY && !side_d)
                 || (mode == MODE_DONLY && side_d);
    end
endmodule

// File: rtl/cfg_cache_line_store.sv
module cfg_cache_line_store #(
    parameter int IDX_W  = 9,
    parameter int WSEL_W = 2,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_word,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              word_we,
    input  logic              tag_we,
    input  logic              clr_we
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = LINES << WSEL_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [WORDS];

    for (genvar l = 0; l < LINES; l++) begin : g_valid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[l] <= 1'b0;
            end else if (tag_we && wr_idx == IDX_W'(l)) begin
                valid_q[l] <= 1'b1;
            end else if (clr_we && wr_idx == IDX_W'(l)) begin
                valid_q[l] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (tag_we) begin
            tag_mem[wr_idx] <= wr_tag;
        end
        if (word_we) begin
            data_mem[{wr_idx, wr_wsel}] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_word  = data_mem[{rd_idx, rd_wsel}];
endmodule

// File: rtl/cfg_cache.sv
module cfg_cache
    import cfg_cache_pkg::*;
#(
    parameter int ADDR_W     = 30,
    parameter int IDX_W      = 9,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_en,
    input  logic              ctl_dis_i,
    input  logic              ctl_dis_d,
    input  logic              ctl_inv_i,
    input  logic              ctl_inv_d,
    output logic              busy,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_addr,
    output logic              if_ack,
    output logic [DATA_W-1:0] if_rdata,
    input  logic              dc_req,
    input  logic              dc_we,
    input  logic [ADDR_W-1:0] dc_addr,
    input  logic [DATA_W-1:0] dc_wdata,
    output logic              dc_ack,
    output logic [DATA_W-1:0] dc_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int HALF_W = IDX_W - 1;
    localparam int TAG_W  = ADDR_W - WSEL_W - HALF_W;

    typedef struct packed {
        cache_state_e      st;
        logic              en;
        logic              dis_i;
        logic              dis_d;
        logic              side_d;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [WSEL_W-1:0] beat;
        logic [IDX_W-1:0]  ptr;
        logic [IDX_W-1:0]  last;
        logic              ack_i;
        logic              ack_d;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    cache_mode_e       mode_cur, mode_new;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_side;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    logic              cacheable;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_word;
    logic              hit;
    logic [IDX_W-1:0]  s_idx;
    logic [WSEL_W-1:0] s_wsel;
    logic [DATA_W-1:0] s_wdata;
    logic              s_word_we, s_tag_we, s_clr_we;

    cfg_cache_mode_dec u_mode_cur (
        .en(r_q.en), .dis_i(r_q.dis_i), .dis_d(r_q.dis_d), .mode(mode_cur)
    );

    cfg_cache_mode_dec u_mode_new (
        .en(ctl_en), .dis_i(ctl_dis_i), .dis_d(ctl_dis_d), .mode(mode_new)
    );

    always_comb begin
        if (r_q.st == ST_IDLE) begin
            sel_side = dc_req;
            sel_addr = dc_req ? dc_addr : if_addr;
        end else begin
            sel_side = r_q.side_d;
            sel_addr = r_q.addr;
        end
    end

    cfg_cache_index_map #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_map (
        .addr(sel_addr), .side_d(sel_side), .mode(mode_cur),
        .idx(idx), .tag(tag), .wsel(wsel), .cacheable(cacheable)
    );

    cfg_cache_line_store #(
        .IDX_W(IDX_W), .WSEL_W(WSEL_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx), .rd_wsel(wsel),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_word(rd_word),
        .wr_idx(s_idx), .wr_wsel(s_wsel), .wr_data(s_wdata), .wr_tag(tag),
        .word_we(s_word_we), .tag_we(s_tag_we), .clr_we(s_clr_we)
    );

    assign hit = rd_valid && (rd_tag == tag);

    always_comb begin
        r_d       = r_q;
        r_d.ack_i = 1'b0;
        r_d.ack_d = 1'b0;
        s_idx     = idx;
        s_wsel    = wsel;
        s_wdata   = mem_rdata;
        s_word_we = 1'b0;
        s_tag_we  = 1'b0;
        s_clr_we  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.addr;
        mem_wdata = r_q.wdata;

        case (r_q.st)
            ST_IDLE: begin
                if (ctl_we) begin
                    r_d.en    = ctl_en;
                    r_d.dis_i = ctl_dis_i;
                    r_d.dis_d = ctl_dis_d;
                    r_d.ptr   = '0;
                    r_d.last  = '1;
                    case (mode_new)
                        MODE_SPLIT: begin
                            if (ctl_inv_i && ctl_inv_d) begin
                                r_d.st = ST_INVAL;
                            end else if (ctl_inv_i) begin
                                r_d.st   = ST_INVAL;
                                r_d.last = {1'b0, {HALF_W{1'b1}}};
                            end else if (ctl_inv_d) begin
                                r_d.st  = ST_INVAL;
                                r_d.ptr = {1'b1, {HALF_W{1'b0}}};
                            end
                        end
                        MODE_IONLY: if (ctl_inv_i) r_d.st = ST_INVAL;
                        MODE_DONLY: if (ctl_inv_d) r_d.st = ST_INVAL;
                        default: ;
                    endcase
                end else if (!(r_q.ack_i || r_q.ack_d) && (dc_req || if_req)) begin
                    r_d.side_d = sel_side;
                    r_d.addr   = sel_addr;
                    r_d.wr     = dc_req && dc_we;
                    r_d.wdata  = dc_wdata;
                    r_d.beat   = '0;
                    if (dc_req && dc_we) begin
                        if (cacheable && hit) begin
                            s_word_we = 1'b1;
                            s_wdata   = dc_wdata;
                        end
                        r_d.st = ST_WRITE;
                    end else if (!cacheable) begin
                        r_d.st = ST_BYPASS;
                    end else if (hit) begin
                        r_d.rdata = rd_word;
                        r_d.ack_d = sel_side;
                        r_d.ack_i = !sel_side;
                    end else begin
                        r_d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {r_q.addr[ADDR_W-1:WSEL_W], r_q.beat};
                if (mem_ack) begin
                    s_word_we = 1'b1;
                    s_wsel    = r_q.beat;
                    if (r_q.beat == wsel) begin
                        r_d.rdata = mem_rdata;
                    end
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == {WSEL_W{1'b1}}) begin
                        s_tag_we  = 1'b1;
                        r_d.st    = ST_IDLE;
                        r_d.ack_d = r_q.side_d;
                        r_d.ack_i = !r_q.side_d;
                    end
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    r_d.st    = ST_IDLE;
                    r_d.ack_d = 1'b1;
                end
            end
            ST_BYPASS: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.st    = ST_IDLE;
                    r_d.rdata = mem_rdata;
                    r_d.ack_d = r_q.side_d;
                    r_d.ack_i = !r_q.side_d;
                end
            end
            ST_INVAL: begin
                s_idx    = r_q.ptr;
                s_clr_we = 1'b1;
                if (r_q.ptr == r_q.last) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.ptr = r_q.ptr + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign if_ack   = r_q.ack_i;
    assign dc_ack   = r_q.ack_d;
    assign if_rdata = r_q.rdata;
    assign dc_rdata = r_q.rdata;
endmodule

// File: rtl/cfg_cache_chk.sv
module cfg_cache_chk #(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              if_req,
    input logic              dc_req,
    input logic              dc_we,
    input logic              if_ack,
    input logic              dc_ack,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    // R13
    ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(if_ack && dc_ack));

    // R13
    if_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_ack |=> !if_ack);

    // R13
    dc_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_ack |=> !dc_ack);

    // R13
    if_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_ack |-> $past(if_req));

    // R13
    dc_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_ack |-> $past(dc_req));

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R7
    mem_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (dc_req && dc_we));

    // R10
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind cfg_cache cfg_cache_chk #(.ADDR_W(ADDR_W)) u_cfg_cache_chk (
    .clk(clk), .rst_n(rst_n), .if_req(if_req), .dc_req(dc_req), .dc_we(dc_we),
    .if_ack(if_ack), .dc_ack(dc_ack), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/cfg_cache_test.sv
module cfg_cache_test;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0, ctl_en = 1'b0, ctl_dis_i = 1'b0, ctl_dis_d = 1'b0;
    logic          ctl_inv_i = 1'b0, ctl_inv_d = 1'b0;
    logic          busy;
    logic          if_req = 1'b0;
    logic [AW-1:0] if_addr = '0;
    logic          if_ack;
    logic [DW-1:0] if_rdata;
    logic          dc_req = 1'b0, dc_we = 1'b0;
    logic [AW-1:0] dc_addr = '0;
    logic [DW-1:0] dc_wdata = '0;
    logic          dc_ack;
    logic [DW-1:0] dc_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] mem_arr [256];
    logic [AW-1:0] rlog [4];
    int n_rd = 0;
    int n_wr = 0;
    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    cfg_cache #(.ADDR_W(AW), .IDX_W(3), .LINE_WORDS(4), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
        .ctl_dis_i(ctl_dis_i), .ctl_dis_d(ctl_dis_d), .ctl_inv_i(ctl_inv_i),
        .ctl_inv_d(ctl_inv_d), .busy(busy), .if_req(if_req), .if_addr(if_addr),
        .if_ack(if_ack), .if_rdata(if_rdata), .dc_req(dc_req), .dc_we(dc_we),
        .dc_addr(dc_addr), .dc_wdata(dc_wdata), .dc_ack(dc_ack), .dc_rdata(dc_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory responder: one transfer per request, acknowledged a cycle later
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_arr[mem_addr] <= mem_wdata;
                n_wr = n_wr + 1;
            end else begin
                mem_rdata <= mem_arr[mem_addr];
                rlog[n_rd % 4] = mem_addr;
                n_rd = n_rd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic acc(input bit dside, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                       output int drd, output int dwr);
        int r0;
        int w0;
        int guard;
        r0 = n_rd;
        w0 = n_wr;
        guard = 0;
        if (dside) begin
            dc_req = 1'b1; dc_we = wr; dc_addr = a; dc_wdata = wd;
        end else begin
            if_req = 1'b1; if_addr = a;
        end
        do begin
            @(negedge clk);
            guard++;
        end while (!(dside ? dc_ack : if_ack) && guard < 500);
        rd = dside ? dc_rdata : if_rdata;
        dc_req = 1'b0; dc_we = 1'b0; if_req = 1'b0;
        drd = n_rd - r0;
        dwr = n_wr - w0;
        @(negedge clk);
        chk(!if_ack && !dc_ack, "R13 ack pulse", {30'd0, if_ack, dc_ack}, 32'd0);
    endtask

    // read and compare with memory; expect a given number of memory reads
    task automatic rd_chk(input bit dside, input logic [AW-1:0] a, input int exp_rd,
                          input string rq);
        logic [DW-1:0] exp;
        logic [DW-1:0] got;
        int drd;
        int dwr;
        exp = mem_arr[a];
        acc(dside, 1'b0, a, '0, got, drd, dwr);
        chk(got == exp, rq, got, exp);
        chk(drd == exp_rd && dwr == 0, rq, drd, exp_rd);
    endtask

    task automatic wr_chk(input logic [AW-1:0] a, input logic [DW-1:0] v, input string rq);
        logic [DW-1:0] got;
        int drd;
        int dwr;
        acc(1'b1, 1'b1, a, v, got, drd, dwr);
        chk(dwr == 1 && drd == 0, rq, dwr, 1);
        chk(mem_arr[a] == v, rq, mem_arr[a], v);
    endtask

    task automatic wr_ctl(input bit en, input bit di, input bit dd, input bit ii,
                          input bit id, input int exp_busy, input string rq);
        int nb;
        ctl_we = 1'b1; ctl_en = en; ctl_dis_i = di; ctl_dis_d = dd;
        ctl_inv_i = ii; ctl_inv_d = id;
        @(negedge clk);
        ctl_we = 1'b0; ctl_inv_i = 1'b0; ctl_inv_d = 1'b0;
        nb = 0;
        while (busy && nb < 1000) begin
            nb++;
            @(negedge clk);
        end
        chk(nb == exp_busy, rq, nb, exp_busy);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < 256; i++) mem_arr[i] = 32'hC0DE_0000 + i * 32'h0001_0037;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !if_ack && !dc_ack && !mem_req, "R1 reset outputs",
            {28'd0, busy, if_ack, dc_ack, mem_req}, 32'd0);
        rd_chk(1'b1, 8'd3, 1, "R1 off after reset");

        // R2 off mode: every read goes to memory, nothing kept
        rd_chk(1'b1, 8'd3, 1, "R2 data repeat");
        rd_chk(1'b1, 8'd77, 1, "R2 data");
        rd_chk(1'b0, 8'd200, 1, "R2 fetch");
        rd_chk(1'b0, 8'd200, 1, "R2 fetch repeat");
        wr_chk(8'd77, 32'h1234_5678, "R2 store");
        rd_chk(1'b1, 8'd77, 1, "R2 read after store");

        // split mode, clearing both halves: R9
        wr_ctl(1, 0, 0, 1, 1, 8, "R9 split both walk");

        // R6 line fill on every instruction line, then hits on every word
        for (int l = 0; l < 4; l++) begin
            s0 = n_rd;
            rd_chk(1'b0, 8'(l * 4 + (l % 4)), 4, "R6 fill count");
            for (int k = 0; k < 4; k++)
                chk(rlog[(s0 + k) % 4] == 8'(l * 4 + k), "R6 fill order",
                    rlog[(s0 + k) % 4], l * 4 + k);
            for (int w = 0; w < 4; w++) rd_chk(1'b0, 8'(l * 4 + w), 0, "R6 hit");
        end
        // R3 data side has its own half even for the same addresses
        for (int l = 0; l < 4; l++) begin
            rd_chk(1'b1, 8'(l * 4), 4, "R3 data fill separate");
            for (int w = 0; w < 4; w++) rd_chk(1'b1, 8'(l * 4 + w), 0, "R3 data hit");
        end
        for (int a = 0; a < 16; a++) rd_chk(1'b0, 8'(a), 0, "R3 instr kept");

        // R12 same index, different tag evicts
        rd_chk(1'b0, 8'd16, 4, "R12 conflict fill");
        rd_chk(1'b0, 8'd0, 4, "R12 evicted");
        rd_chk(1'b1, 8'd0, 0, "R12 other side unaffected");

        // R7 write-through
        wr_chk(8'd1, 32'hAAAA_0001, "R7 store hit");
        rd_chk(1'b1, 8'd1, 0, "R7 hit updated");
        wr_chk(8'd100, 32'hBBBB_0100, "R7 store miss");
        rd_chk(1'b1, 8'd100, 4, "R7 no allocate");

        // R8 one-side invalidate in split mode
        wr_ctl(1, 0, 0, 0, 1, 4, "R8 data half walk");
        rd_chk(1'b0, 8'd0, 0, "R8 instr survives");
        rd_chk(1'b1, 8'd1, 4, "R8 data cleared");
        wr_ctl(1, 0, 0, 1, 0, 4, "R8 instr half walk");
        rd_chk(1'b1, 8'd1, 0, "R8 data survives");
        rd_chk(1'b0, 8'd0, 4, "R8 instr cleared");
        wr_ctl(1, 0, 0, 0, 0, 0, "R8 no invalidate");
        rd_chk(1'b1, 8'd1, 0, "R8 no invalidate keeps data");

        // R11 data port first when both request together
        dc_req = 1'b1; dc_we = 1'b0; dc_addr = 8'd1;
        if_req = 1'b1; if_addr = 8'd0;
        @(negedge clk);
        chk(dc_ack && !if_ack, "R11 data first", {30'd0, dc_ack, if_ack}, 32'd2);
        chk(dc_rdata == mem_arr[1], "R11 data value", dc_rdata, mem_arr[1]);
        dc_req = 1'b0;
        begin
            int g;
            g = 0;
            while (!if_ack && g < 50) begin
                @(negedge clk);
                g++;
            end
        end
        chk(if_ack && if_rdata == mem_arr[0], "R11 fetch after", if_rdata, mem_arr[0]);
        if_req = 1'b0;
        @(negedge clk);

        // R9 both halves cleared
        wr_ctl(1, 0, 0, 1, 1, 8, "R9 split both again");
        rd_chk(1'b0, 8'd0, 4, "R9 instr cleared");
        rd_chk(1'b1, 8'd1, 4, "R9 data cleared");

        // R4 instruction-only: eight lines for fetches, data bypasses
        wr_ctl(1, 0, 1, 1, 0, 8, "R9 unified instr walk");
        for (int l = 0; l < 8; l++) rd_chk(1'b0, 8'(l * 4), 4, "R4 fill");
        for (int a = 0; a < 32; a++) rd_chk(1'b0, 8'(a), 0, "R4 all lines kept");
        rd_chk(1'b1, 8'd5, 1, "R4 data bypass");
        rd_chk(1'b1, 8'd5, 1, "R4 data bypass repeat");
        wr_chk(8'd200, 32'hCCCC_0200, "R4 data store");
        wr_ctl(1, 0, 1, 0, 1, 0, "R9 inactive side");
        rd_chk(1'b0, 8'd0, 0, "R9 inactive side no effect");

        // R5 data-only
        wr_ctl(1, 1, 0, 0, 1, 8, "R9 unified data walk");
        for (int l = 0; l < 8; l++) rd_chk(1'b1, 8'(l * 4 + 3), 4, "R5 fill");
        for (int a = 0; a < 32; a++) rd_chk(1'b1, 8'(a), 0, "R5 all lines kept");
        rd_chk(1'b0, 8'd9, 1, "R5 fetch bypass");
        rd_chk(1'b1, 8'd32, 4, "R12 unified conflict");
        rd_chk(1'b1, 8'd0, 4, "R12 unified evicted");

        // R2 both sides disabled and global enable clear
        wr_ctl(1, 1, 1, 1, 1, 0, "R9 both disabled");
        rd_chk(1'b1, 8'd0, 1, "R2 both disabled bypass");
        wr_ctl(0, 0, 0, 1, 1, 0, "R9 off no walk");
        rd_chk(1'b0, 8'd0, 1, "R2 enable clear bypass");
        rd_chk(1'b1, 8'd1, 1, "R2 enable clear data");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule